// File: doc/BRIEF.md
# Receive Overflow Error Reporter

This block sits beside a multichannel receive FIFO and turns per-channel overflow events into status and interrupt signalling. When a message overflows, the block does not write status straight away. It marks the channel as pending. When that message later reaches the head of the FIFO, the block issues a one-cycle status-write strobe. The strobe carries a final status word: owner set to host, end-of-message set, and an error code for a buffer error. The data received before the overflow is closed out by that status word.

A maskable error interrupt is raised on the first overflow of a run. Further overflows on the same channel are dropped silently until a message on that channel completes without an overflow. The head-of-FIFO side is never stalled: every head event is taken in the cycle it is presented, and there is no ready signal. A config bit can suppress the status write while still consuming the pending marker.

Top module: `rx_ovf_reporter`

## Requirements
- R1: After reset, `sts_wr` and `err_irq` are 0, all status fields and channel outputs are 0, and no channel holds a pending overflow or a suppression run.
- R2: `sts_wr` pulses for exactly one cycle, in the cycle after `head_vld` is sampled for a channel that holds a pending overflow. `sts_ch` then equals that `head_ch`. The strobe does not occur at any other time.
- R3: While `sts_wr` is 1, `sts_owner_host`=1, `sts_eom`=1 and `sts_err`=3'b001 (buffer error). The code 3'b010 is reserved for a frame-alignment error and 3'b000 means no error. While `sts_wr` is 0, all three fields are 0.
- R4: With `cfg_inhibit_sts`=1 when the head event is sampled, no status write occurs. The pending overflow is still consumed, so a later head event on that channel produces no write.
- R5: `err_irq` pulses in the cycle after an accepted overflow, with `err_irq_ch` equal to `ovf_ch`, only when `cfg_err_ie`=1 at that sample.
- R6: An overflow on a channel whose suppression run is active produces no interrupt and no additional status write.
- R7: A head event on a channel with no pending overflow ends that channel's suppression run, so the next overflow on it is reported again.
- R8: Channels are independent. Events on one channel never change the pending or run state of another, and any channel 0..NCH-1 may be used.
- R9: The head side is never stalled. Head events in consecutive cycles each produce their own status write in consecutive cycles.
- R10: When a head event and an overflow arrive for the same channel in the same cycle, the overflow is judged against the run state held before that cycle. An overflow arriving while the run is active is ignored, even if the head event ends the run in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_inhibit_sts | input | 1 | Suppress status word writes |
| cfg_err_ie | input | 1 | Error interrupt enable |
| ovf_vld | input | 1 | Overflow event strobe |
| ovf_ch | input | CHW | Channel of the overflow event |
| head_vld | input | 1 | A message reached the FIFO head |
| head_ch | input | CHW | Channel of the head message |
| sts_wr | output | 1 | Status word write strobe |
| sts_ch | output | CHW | Channel of the status write |
| sts_owner_host | output | 1 | Owner field, 1 = host |
| sts_eom | output | 1 | End-of-message field |
| sts_err | output | 3 | Error code field |
| err_irq | output | 1 | Error interrupt pulse |
| err_irq_ch | output | CHW | Channel of the interrupt |

## Verification
The in-line assertions check several rules on every cycle. A status strobe must follow a head event, carry that event's channel and fixed field values, and never appear under inhibit. An interrupt must follow an enabled overflow on a channel whose run was clear. Other behaviour depends on histories of events, and only the bench scenarios can show it. These cover the run ending at a clean head, a consumed-but-inhibited pending marker, back-to-back heads, and the same-cycle ordering of head and overflow on one channel. Its scoreboard replays each scenario against its own per-channel model.

// File: rtl/rx_ovf_reporter.sv
module rx_ovf_reporter #(
  parameter int NCH = 32,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_inhibit_sts,
  input  logic           cfg_err_ie,
  input  logic           ovf_vld,
  input  logic [CHW-1:0] ovf_ch,
  input  logic           head_vld,
  input  logic [CHW-1:0] head_ch,
  output logic           sts_wr,
  output logic [CHW-1:0] sts_ch,
  output logic           sts_owner_host,
  output logic           sts_eom,
  output logic [2:0]     sts_err,
  output logic           err_irq,
  output logic [CHW-1:0] err_irq_ch
);
  localparam logic [2:0] ERR_BUFF = 3'b001;

  logic [NCH-1:0] pend, run, pend_n, run_n;
  logic ovf_take, head_hit;

  assign ovf_take = ovf_vld && !run[ovf_ch];
  assign head_hit = head_vld && pend[head_ch];

  always_comb begin
    pend_n = pend;
    run_n  = run;
    if (head_vld) begin
      if (pend[head_ch]) pend_n[head_ch] = 1'b0;
      else               run_n[head_ch]  = 1'b0;
    end
    if (ovf_take) begin
      pend_n[ovf_ch] = 1'b1;
      run_n[ovf_ch]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      run <= '0;
      sts_wr <= 1'b0;
      sts_ch <= '0;
      err_irq <= 1'b0;
      err_irq_ch <= '0;
    end else begin
      pend <= pend_n;
      run <= run_n;
      sts_wr <= head_hit && !cfg_inhibit_sts;
      sts_ch <= (head_hit && !cfg_inhibit_sts) ? head_ch : '0;
      err_irq <= ovf_take && cfg_err_ie;
      err_irq_ch <= (ovf_take && cfg_err_ie) ? ovf_ch : '0;
    end
  end

  assign sts_owner_host = sts_wr;
  assign sts_eom = sts_wr;
  assign sts_err = sts_wr ? ERR_BUFF : 3'b000;

  // R2
  sts_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> ($past(head_vld) && sts_ch == $past(head_ch)));
  // R3
  sts_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> (sts_owner_host && sts_eom && sts_err == 3'b001));
  // R4
  sts_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |-> !$past(cfg_inhibit_sts));
  // R5
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ($past(cfg_err_ie && ovf_vld) && err_irq_ch == $past(ovf_ch)));
  // R6
  irq_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> !$past(run[ovf_ch]));
endmodule

// File: tb/sim_rx_ovf_reporter.sv
`timescale 1ns/1ps
module sim_rx_ovf_reporter;
  localparam int NCH = 32;
  localparam int CHW = 5;

  typedef struct { int ch; int due; string req; } exp_t;

  logic clk = 0, rst_n = 0;
  logic cfg_inhibit_sts = 0, cfg_err_ie = 0, ovf_vld = 0, head_vld = 0;
  logic [CHW-1:0] ovf_ch = '0, head_ch = '0;
  logic sts_wr, sts_owner_host, sts_eom, err_irq;
  logic [CHW-1:0] sts_ch, err_irq_ch;
  logic [2:0] sts_err;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_on = 0;
  bit m_pend[NCH], m_run[NCH];
  exp_t sts_q[$], irq_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_ovf_reporter #(.NCH(NCH)) u0 (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit ov, int och, bit hd, int hch, bit inh, bit ie, string req);
    bit old_run;
    @(negedge clk);
    ovf_vld = ov; ovf_ch = och[CHW-1:0];
    head_vld = hd; head_ch = hch[CHW-1:0];
    cfg_inhibit_sts = inh; cfg_err_ie = ie;
    old_run = m_run[och];
    if (hd) begin
      if (m_pend[hch]) begin
        if (!inh) sts_q.push_back('{hch, cyc + 1, req});
        m_pend[hch] = 0;
      end else m_run[hch] = 0;
    end
    if (ov && !old_run) begin
      m_pend[och] = 1; m_run[och] = 1;
      if (ie) irq_q.push_back('{och, cyc + 1, req});
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, "idle");
  endtask

  always @(negedge clk) if (mon_on) begin
    if (sts_wr) begin
      if (sts_q.size() == 0 || sts_q[0].due != cyc)
        chk(0, "R2 unexpected status write", int'(sts_ch), -1);
      else begin
        chk(int'(sts_ch) == sts_q[0].ch, {sts_q[0].req, " status channel"}, int'(sts_ch), sts_q[0].ch);
        chk(sts_owner_host && sts_eom && sts_err == 3'b001, "R3 status fields",
            int'({sts_owner_host, sts_eom, sts_err}), 'b11001);
        void'(sts_q.pop_front());
      end
    end else begin
      if (sts_owner_host || sts_eom || sts_err != 0)
        chk(0, "R3 idle fields nonzero", int'({sts_owner_host, sts_eom, sts_err}), 0);
      if (sts_q.size() != 0 && sts_q[0].due == cyc) begin
        chk(0, {sts_q[0].req, " missing status write"}, 0, sts_q[0].ch);
        void'(sts_q.pop_front());
      end
    end
    if (err_irq) begin
      if (irq_q.size() == 0 || irq_q[0].due != cyc)
        chk(0, "R6 unexpected interrupt", int'(err_irq_ch), -1);
      else begin
        chk(int'(err_irq_ch) == irq_q[0].ch, {irq_q[0].req, " interrupt channel"}, int'(err_irq_ch), irq_q[0].ch);
        void'(irq_q.pop_front());
      end
    end else if (irq_q.size() != 0 && irq_q[0].due == cyc) begin
      chk(0, {irq_q[0].req, " missing interrupt"}, 0, irq_q[0].ch);
      void'(irq_q.pop_front());
    end
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sts_wr == 0, "R1 sts_wr after reset", sts_wr, 0);
    chk(err_irq == 0, "R1 err_irq after reset", err_irq, 0);
    chk(sts_err == 0 && sts_ch == 0, "R1 fields after reset", int'(sts_err), 0);
    mon_on = 1;
    // R1 no pending: head produces nothing
    step(0, 0, 1, 4, 0, 1, "R1"); idle(2);
    // R5 R2 R3 basic
    step(1, 3, 0, 0, 0, 1, "R5"); idle(1);
    step(0, 0, 1, 3, 0, 1, "R2"); idle(2);
    // R6 repeated overflow suppressed
    step(1, 3, 0, 0, 0, 1, "R6"); idle(1);
    step(0, 0, 1, 3, 0, 1, "R6"); idle(1);
    // R7 run ended, report again
    step(1, 3, 0, 0, 0, 1, "R7"); idle(1);
    step(0, 0, 1, 3, 0, 1, "R7"); idle(1);
    step(0, 0, 1, 3, 0, 1, "R7"); idle(1);
    // R5 interrupts disabled
    step(1, 5, 0, 0, 0, 0, "R5"); idle(1);
    step(0, 0, 1, 5, 0, 1, "R5"); idle(1);
    // R4 inhibit consumes pending
    step(1, 7, 0, 0, 0, 1, "R4"); idle(1);
    step(0, 0, 1, 7, 1, 1, "R4"); idle(1);
    step(0, 0, 1, 7, 0, 1, "R4"); idle(1);
    step(1, 7, 0, 0, 0, 1, "R4"); idle(1);
    step(0, 0, 1, 7, 0, 1, "R4"); idle(2);
    // R8 independent channels, edges 0 and 31
    step(1, 0, 0, 0, 0, 1, "R8");
    step(1, 31, 1, 0, 0, 1, "R8");
    step(1, 1, 1, 2, 0, 1, "R8");
    step(0, 0, 1, 31, 0, 1, "R8");
    step(0, 0, 1, 1, 0, 1, "R8"); idle(2);
    // R9 back-to-back heads
    step(1, 10, 0, 0, 0, 1, "R9");
    step(1, 11, 0, 0, 0, 1, "R9");
    step(0, 0, 1, 10, 0, 1, "R9");
    step(0, 0, 1, 11, 0, 1, "R9"); idle(2);
    // R10 same-cycle head and overflow on one channel
    step(1, 12, 0, 0, 0, 1, "R10"); idle(1);
    step(1, 12, 1, 12, 0, 1, "R10"); idle(1);
    step(1, 12, 1, 12, 0, 1, "R10"); idle(1);
    step(1, 12, 1, 12, 0, 1, "R10"); idle(1);
    step(0, 0, 1, 12, 0, 1, "R10"); idle(1);
    step(0, 0, 1, 12, 0, 1, "R10");
    idle(4);
    // R9 nothing left unobserved
    chk(sts_q.size() == 0, "R9 status queue drained", sts_q.size(), 0);
    chk(irq_q.size() == 0, "R9 interrupt queue drained", irq_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule